// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the hardwired sequencer of a small 32-bit load/store processor built on a multi-cycle datapath. It steps through one state per register transfer and, in each state, drives the load enables of the datapath registers, the two ALU operand bus selects, the ALU operation, the register-file port controls and the memory strobes. The datapath, register file, ALU and memory sit outside the block.

Every instruction begins with the same two fetch states and one operand-read state. The operand-read state loads A and B from the two source fields, whatever the opcode. The 6-bit opcode is then decoded into 64 one-hot lines, and these lines choose a per-class sequence. The classes are register ALU, immediate ALU, load, store, conditional branch, PC-relative jump, register-indirect jump and jump-and-link. Memory states hold until the memory reports ready. The branch target is loaded only if the compare, sampled one state earlier, came out true. The immediate and jump-offset selects stand for sign-extended fields, and the datapath performs the extension. Every sequence returns to the first fetch state when it ends.

Top module: `mc_ctrl`

## Requirements
- R1: Fetch takes two states. The first state asserts only ld_en bit 0 (MAR) with s1_sel=1 (PC), s2_sel=4 (zero) and alu_op=0 (add). The second state asserts mem_rd with s1_sel=1, s2_sel=3 (constant four) and alu_op=0. In that second state, ld_en bits 2 (IR) and 3 (PC) are raised together only while mem_rdy is high, and the state repeats while mem_rdy is low.
- R2: The state after fetch asserts ld_en bits 4 (A) and 5 (B) with rd2_sel=0 (second read port addresses the rs2 field), for every opcode, including opcodes that are not defined. In every state, any field not named in these requirements reads zero.
- R3: Opcode 0x00 (register ALU) runs two states. The first has s1_sel=0 (A), s2_sel=0 (B), alu_op=funct[3:0] and ld_en bit 6 (C). The second has rf_we=1, wa_sel=0 (rd field) and wd_sel=0 (data from C).
- R4: Opcodes 0x08 to 0x0D (immediate ALU) follow the R3 sequence, except that s2_sel=1 (IR[15:0], sign-extended) and alu_op is the low three opcode bits.
- R5: Opcode 0x23 (load) first loads MAR with s1_sel=0, s2_sel=1 and alu_op=0. It then asserts mem_rd with s1_sel=2 (MDR) and s2_sel=4, and raises ld_en bit 6 only while mem_rdy is high, repeating while it is low. The last state is the R3 write-back state.
- R6: Opcode 0x2B (store) runs three steps. First it reloads B with rd2_sel=1 (rd field). Then it loads MAR as in R5. Finally it asserts mem_wr, ld_en bit 1 (MDR) and mdr_sel=1 (MDR from B), repeating until mem_rdy is high, and rf_we is never raised.
- R7: Opcode 0x04 (branch) first compares A and B with alu_op=6 and no load enables. The next state drives s1_sel=1 and s2_sel=1, and raises ld_en bit 3 only if br_true was high during the compare state.
- R8: Opcode 0x02 (PC-relative jump) loads PC with s1_sel=1, s2_sel=2 (IR[25:0], sign-extended). Opcode 0x12 (register-indirect jump) loads PC with s1_sel=0, s2_sel=1.
- R9: Opcode 0x03 (jump-and-link) first writes the register file with rf_we=1, wa_sel=1 (register 31) and wd_sel=1 (data from PC), then runs the R8 PC-relative jump state.
- R10: An undefined opcode is followed directly by the first fetch state, with no register-file write, memory write or extra load.
- R11: A synchronous active-high rst forces the first fetch state's control word on the next clock edge, even in the middle of a sequence.
- R12: Each sequence returns to the first fetch state after its last state, and mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| funct | input | FN_W | Function field of the instruction register |
| br_true | input | 1 | Branch condition from the ALU |
| mem_rdy | input | 1 | Memory ready |
| ld_en | output | 7 | Register loads: 0 MAR, 1 MDR, 2 IR, 3 PC, 4 A, 5 B, 6 C |
| rf_we | output | 1 | Register-file write enable |
| rd2_sel | output | 1 | Second read port address: 0 rs2, 1 rd |
| wa_sel | output | 1 | Write address: 0 rd, 1 register 31 |
| wd_sel | output | 1 | Write data: 0 C, 1 PC |
| s1_sel | output | 2 | S1 bus source: 0 A, 1 PC, 2 MDR |
| s2_sel | output | 3 | S2 bus source: 0 B, 1 imm16, 2 imm26, 3 four, 4 zero |
| alu_op | output | ALU_W | ALU operation, 0 add, 6 equality compare |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mdr_sel | output | 1 | MDR source: 0 memory, 1 B |

## Verification
The bound checker watches several properties on every cycle. The memory strobes never overlap. IR and PC load together with the plus-four selects, and the next state is always the A/B operand read. A pending fetch or store repeats while memory is not ready. A write to register 31 always carries PC data, and a store never writes the register file. The branch target load must match the condition sampled one cycle earlier, and an undefined opcode must fall straight back to fetch. Only the bench scenarios can show the full state order of each class, the ALU codes taken from funct or opcode, exact wait counts, the untaken branch, and a reset that lands in the middle of a store.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int ALU_W = 4;

  typedef enum logic [3:0] {
    ST_FETCH_A, ST_FETCH_B, ST_OPRD, ST_ALU_RR, ST_ALU_RI, ST_WBACK,
    ST_LD_ADDR, ST_LD_MEM, ST_ST_RELD, ST_ST_ADDR, ST_ST_MEM,
    ST_BR_CMP, ST_BR_TGT, ST_JMP_REL, ST_JMP_REG, ST_JAL_LNK
  } state_e;

  typedef enum logic [3:0] {
    CL_BAD, CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH, CL_JREL, CL_JREG, CL_JAL
  } class_e;

  // load-enable bit positions
  localparam int LD_MAR = 0, LD_MDR = 1, LD_IR = 2, LD_PC = 3;
  localparam int LD_A = 4, LD_B = 5, LD_C = 6, LD_N = 7;

  localparam logic [1:0] S1_A = 2'd0, S1_PC = 2'd1, S1_MDR = 2'd2;
  localparam logic [2:0] S2_B = 3'd0, S2_IMM16 = 3'd1, S2_IMM26 = 3'd2,
                         S2_FOUR = 3'd3, S2_ZERO = 3'd4;
  localparam logic [ALU_W-1:0] ALU_ADD = 4'd0, ALU_SEQ = 4'd6;

  // opcode lines that the decoder groups into classes
  localparam int OP_RR = 0, OP_JREL = 2, OP_JAL = 3, OP_BR = 4;
  localparam int OP_RI_LO = 8, OP_RI_HI = 13, OP_JREG = 18;
  localparam int OP_LOAD = 35, OP_STORE = 43;

  typedef struct packed {
    logic [LD_N-1:0]  ld;
    logic             rf_we;
    logic             rd2_rd;
    logic             wa_r31;
    logic             wd_pc;
    logic [1:0]       s1;
    logic [2:0]       s2;
    logic [ALU_W-1:0] alu;
    logic             mem_rd;
    logic             mem_wr;
    logic             mdr_b;
    logic             gate_rdy;
    logic             gate_cond;
  } cword_t;
endpackage

// File: rtl/mc_opdec.sv
module mc_opdec
  import mc_ctrl_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output class_e           cls
);
  localparam int LINES = 1 << OPC_W;

  logic [LINES-1:0] line;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line[i] = (opcode == OPC_W'(i));
  end

  always_comb begin
    cls = CL_BAD;
    if (line[OP_RR])                 cls = CL_RR;
    if (|line[OP_RI_HI:OP_RI_LO])    cls = CL_RI;
    if (line[OP_LOAD])               cls = CL_LOAD;
    if (line[OP_STORE])              cls = CL_STORE;
    if (line[OP_BR])                 cls = CL_BRANCH;
    if (line[OP_JREL])               cls = CL_JREL;
    if (line[OP_JREG])               cls = CL_JREG;
    if (line[OP_JAL])                cls = CL_JAL;
  end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  class_e cls,
  input  logic   mem_rdy,
  input  logic   br_true,
  output state_e state_q,
  output state_e state_d,
  output logic   cond_q
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH_A: state_d = ST_FETCH_B;
      ST_FETCH_B: if (mem_rdy) state_d = ST_OPRD;
      ST_OPRD: begin
        case (cls)
          CL_RR:     state_d = ST_ALU_RR;
          CL_RI:     state_d = ST_ALU_RI;
          CL_LOAD:   state_d = ST_LD_ADDR;
          CL_STORE:  state_d = ST_ST_RELD;
          CL_BRANCH: state_d = ST_BR_CMP;
          CL_JREL:   state_d = ST_JMP_REL;
          CL_JREG:   state_d = ST_JMP_REG;
          CL_JAL:    state_d = ST_JAL_LNK;
          default:   state_d = ST_FETCH_A;
        endcase
      end
      ST_ALU_RR, ST_ALU_RI: state_d = ST_WBACK;
      ST_LD_ADDR: state_d = ST_LD_MEM;
      ST_LD_MEM:  if (mem_rdy) state_d = ST_WBACK;
      ST_ST_RELD: state_d = ST_ST_ADDR;
      ST_ST_ADDR: state_d = ST_ST_MEM;
      ST_ST_MEM:  if (mem_rdy) state_d = ST_FETCH_A;
      ST_BR_CMP:  state_d = ST_BR_TGT;
      ST_JAL_LNK: state_d = ST_JMP_REL;
      default:    state_d = ST_FETCH_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH_A;
      cond_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_BR_CMP) cond_q <= br_true;
    end
  end
endmodule

// File: rtl/mc_cword.sv
module mc_cword
  import mc_ctrl_pkg::*;
#(
  parameter int FN_W = 6
) (
  input  state_e          st,
  input  logic [FN_W-1:0] funct,
  input  logic [2:0]      ri_op,
  output cword_t          cw
);
  always_comb begin
    cw = '0;
    case (st)
      ST_FETCH_A: begin
        cw.ld[LD_MAR] = 1'b1; cw.s1 = S1_PC; cw.s2 = S2_ZERO; cw.alu = ALU_ADD;
      end
      ST_FETCH_B: begin
        cw.ld[LD_IR] = 1'b1; cw.ld[LD_PC] = 1'b1; cw.s1 = S1_PC; cw.s2 = S2_FOUR;
        cw.mem_rd = 1'b1; cw.gate_rdy = 1'b1;
      end
      ST_OPRD: begin
        cw.ld[LD_A] = 1'b1; cw.ld[LD_B] = 1'b1;
      end
      ST_ALU_RR: begin
        cw.ld[LD_C] = 1'b1; cw.s1 = S1_A; cw.s2 = S2_B; cw.alu = ALU_W'(funct);
      end
      ST_ALU_RI: begin
        cw.ld[LD_C] = 1'b1; cw.s1 = S1_A; cw.s2 = S2_IMM16; cw.alu = ALU_W'(ri_op);
      end
      ST_WBACK: cw.rf_we = 1'b1;
      ST_LD_ADDR, ST_ST_ADDR: begin
        cw.ld[LD_MAR] = 1'b1; cw.s1 = S1_A; cw.s2 = S2_IMM16; cw.alu = ALU_ADD;
      end
      ST_LD_MEM: begin
        cw.ld[LD_C] = 1'b1; cw.s1 = S1_MDR; cw.s2 = S2_ZERO;
        cw.mem_rd = 1'b1; cw.gate_rdy = 1'b1;
      end
      ST_ST_RELD: begin
        cw.ld[LD_B] = 1'b1; cw.rd2_rd = 1'b1;
      end
      ST_ST_MEM: begin
        cw.ld[LD_MDR] = 1'b1; cw.mdr_b = 1'b1; cw.mem_wr = 1'b1;
      end
      ST_BR_CMP: begin
        cw.s1 = S1_A; cw.s2 = S2_B; cw.alu = ALU_SEQ;
      end
      ST_BR_TGT: begin
        cw.ld[LD_PC] = 1'b1; cw.s1 = S1_PC; cw.s2 = S2_IMM16; cw.gate_cond = 1'b1;
      end
      ST_JMP_REL: begin
        cw.ld[LD_PC] = 1'b1; cw.s1 = S1_PC; cw.s2 = S2_IMM26;
      end
      ST_JMP_REG: begin
        cw.ld[LD_PC] = 1'b1; cw.s1 = S1_A; cw.s2 = S2_IMM16;
      end
      ST_JAL_LNK: begin
        cw.rf_we = 1'b1; cw.wa_r31 = 1'b1; cw.wd_pc = 1'b1;
      end
      default: cw = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             br_true,
  input  logic             mem_rdy,
  output logic [LD_N-1:0]  ld_en,
  output logic             rf_we,
  output logic             rd2_sel,
  output logic             wa_sel,
  output logic             wd_sel,
  output logic [1:0]       s1_sel,
  output logic [2:0]       s2_sel,
  output logic [ALU_W-1:0] alu_op,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mdr_sel
);
  class_e cls;
  state_e state_q, state_d, st_word;
  logic   cond_q, hold;
  cword_t cw_d, cw_q;

  mc_opdec #(.OPC_W(OPC_W)) u_dec (.opcode(opcode), .cls(cls));

  mc_seq u_seq (
    .clk(clk), .rst(rst), .cls(cls), .mem_rdy(mem_rdy), .br_true(br_true),
    .state_q(state_q), .state_d(state_d), .cond_q(cond_q)
  );

  // the word for the coming state is computed one cycle ahead and registered
  assign st_word = rst ? ST_FETCH_A : state_d;

  mc_cword #(.FN_W(FN_W)) u_word (
    .st(st_word), .funct(funct), .ri_op(opcode[2:0]), .cw(cw_d)
  );

  always_ff @(posedge clk) cw_q <= cw_d;

  // loads that must wait for memory or for a true branch condition
  assign hold = (cw_q.gate_rdy & ~mem_rdy) | (cw_q.gate_cond & ~cond_q);

  assign ld_en   = hold ? '0 : cw_q.ld;
  assign rf_we   = hold ? 1'b0 : cw_q.rf_we;
  assign rd2_sel = cw_q.rd2_rd;
  assign wa_sel  = cw_q.wa_r31;
  assign wd_sel  = cw_q.wd_pc;
  assign s1_sel  = cw_q.s1;
  assign s2_sel  = cw_q.s2;
  assign alu_op  = cw_q.alu;
  assign mem_rd  = cw_q.mem_rd;
  assign mem_wr  = cw_q.mem_wr;
  assign mdr_sel = cw_q.mdr_b;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             br_true,
  input logic             mem_rdy,
  input logic [LD_N-1:0]  ld_en,
  input logic             rf_we,
  input logic             rd2_sel,
  input logic             wa_sel,
  input logic             wd_sel,
  input logic [1:0]       s1_sel,
  input logic [2:0]       s2_sel,
  input logic             mem_rd,
  input logic             mem_wr
);
  localparam logic [LD_N-1:0] AB_ONLY  = (LD_N'(1) << LD_A) | (LD_N'(1) << LD_B);
  localparam logic [LD_N-1:0] MAR_ONLY = LD_N'(1) << LD_MAR;

  logic op_known;
  always_comb begin
    op_known = 1'b0;
    case (int'(opcode))
      OP_RR, OP_JREL, OP_JAL, OP_BR, OP_JREG, OP_LOAD, OP_STORE: op_known = 1'b1;
      default: op_known = (int'(opcode) >= OP_RI_LO) && (int'(opcode) <= OP_RI_HI);
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R12
  AST_IR_WITH_PC: assert property (@(posedge clk) disable iff (rst)
    ld_en[LD_IR] |-> (ld_en[LD_PC] && s1_sel == S1_PC && s2_sel == S2_FOUR)); // R1
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && s2_sel == S2_FOUR && !mem_rdy) |=> (mem_rd && s2_sel == S2_FOUR)); // R1
  AST_OPRD_NEXT: assert property (@(posedge clk) disable iff (rst)
    ld_en[LD_IR] |=> (ld_en == AB_ONLY && !rd2_sel)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_rdy) |=> mem_wr); // R6
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !rf_we); // R6
  AST_BR_GATE: assert property (@(posedge clk) disable iff (rst)
    (s1_sel == S1_PC && s2_sel == S2_IMM16) |-> (ld_en[LD_PC] == $past(br_true))); // R7
  AST_LINK_SRC: assert property (@(posedge clk) disable iff (rst)
    (rf_we && wa_sel) |-> wd_sel); // R9
  AST_BAD_OP: assert property (@(posedge clk) disable iff (rst)
    (ld_en == AB_ONLY && !op_known) |=>
      (ld_en == MAR_ONLY && !rf_we && !mem_wr && s1_sel == S1_PC && s2_sel == S2_ZERO)); // R10
endmodule

bind mc_ctrl mc_ctrl_chk #(.OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .br_true(br_true), .mem_rdy(mem_rdy),
  .ld_en(ld_en), .rf_we(rf_we), .rd2_sel(rd2_sel), .wa_sel(wa_sel), .wd_sel(wd_sel),
  .s1_sel(s1_sel), .s2_sel(s2_sel), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/mc_ctrl_tb.sv
module mc_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1, br_true = 1'b0, mem_rdy = 1'b0;
  logic [5:0] opcode = '0, funct = '0;
  logic [6:0] ld_en;
  logic rf_we, rd2_sel, wa_sel, wd_sel, mem_rd, mem_wr, mdr_sel;
  logic [1:0] s1_sel;
  logic [2:0] s2_sel;
  logic [3:0] alu_op;

  always #5 clk = ~clk;

  mc_ctrl u_dut (.*);

  typedef struct { logic [22:0] w; string tag; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [22:0] cw(input logic [6:0] ld, input logic we, input logic rd2,
      input logic wa, input logic wd, input logic [1:0] s1, input logic [2:0] s2,
      input logic [3:0] alu, input logic mrd, input logic mwr, input logic msrc);
    return {ld, we, rd2, wa, wd, s1, s2, alu, mrd, mwr, msrc};
  endfunction

  localparam logic [22:0] W_F0  = {7'h01, 4'b0, 2'd1, 3'd4, 4'd0, 3'b000};
  localparam logic [22:0] W_F1W = {7'h00, 4'b0, 2'd1, 3'd3, 4'd0, 3'b100};
  localparam logic [22:0] W_F1R = {7'h0C, 4'b0, 2'd1, 3'd3, 4'd0, 3'b100};
  localparam logic [22:0] W_RD  = {7'h30, 4'b0, 2'd0, 3'd0, 4'd0, 3'b000};
  localparam logic [22:0] W_WB  = {7'h00, 4'b1000, 2'd0, 3'd0, 4'd0, 3'b000};
  localparam logic [22:0] W_MAR = {7'h01, 4'b0, 2'd0, 3'd1, 4'd0, 3'b000};
  localparam logic [22:0] W_JMP = {7'h08, 4'b0, 2'd1, 3'd2, 4'd0, 3'b000};

  // driver: pushes the word expected for the current cycle, then advances
  task automatic step(input logic [22:0] w, input string tag);
    item_t it;
    it.w = w; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares one queued word per cycle, away from the edges
  initial forever begin
    @(negedge clk);
    #2;
    if (sb.size() > 0) begin
      item_t it;
      logic [22:0] act;
      it  = sb.pop_front();
      act = {ld_en, rf_we, rd2_sel, wa_sel, wd_sel, s1_sel, s2_sel, alu_op, mem_rd, mem_wr, mdr_sel};
      n_cmp++;
      if (act !== it.w) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.w);
      end
    end
  end

  task automatic fetch(input int waits, input string t0);
    mem_rdy = 1'b0;
    step(W_F0, t0);
    for (int i = 0; i < waits; i++) step(W_F1W, "R1");
    mem_rdy = 1'b1;
    step(W_F1R, "R1");
    step(W_RD, "R2");
  endtask

  task automatic do_rr(input logic [5:0] f, input int waits);
    opcode = 6'h00; funct = f;
    fetch(waits, "R1");
    step(cw(7'h40, 0, 0, 0, 0, 2'd0, 3'd0, f[3:0], 0, 0, 0), "R3");
    step(W_WB, "R3");
  endtask

  task automatic do_ri(input logic [5:0] op);
    opcode = op; funct = 6'h3F;
    fetch(0, "R12");
    step(cw(7'h40, 0, 0, 0, 0, 2'd0, 3'd1, {1'b0, op[2:0]}, 0, 0, 0), "R4");
    step(W_WB, "R4");
  endtask

  task automatic do_ld(input int fw, input int mw);
    opcode = 6'h23;
    fetch(fw, "R12");
    step(W_MAR, "R5");
    mem_rdy = 1'b0;
    for (int i = 0; i < mw; i++) step(cw(7'h00, 0, 0, 0, 0, 2'd2, 3'd4, 4'd0, 1, 0, 0), "R5");
    mem_rdy = 1'b1;
    step(cw(7'h40, 0, 0, 0, 0, 2'd2, 3'd4, 4'd0, 1, 0, 0), "R5");
    step(W_WB, "R5");
  endtask

  task automatic st_front();
    opcode = 6'h2B;
    fetch(1, "R12");
    step(cw(7'h20, 0, 1, 0, 0, 2'd0, 3'd0, 4'd0, 0, 0, 0), "R6");
    step(W_MAR, "R6");
  endtask

  task automatic do_st(input int mw);
    st_front();
    mem_rdy = 1'b0;
    for (int i = 0; i < mw; i++) step(cw(7'h02, 0, 0, 0, 0, 2'd0, 3'd0, 4'd0, 0, 1, 1), "R6");
    mem_rdy = 1'b1;
    step(cw(7'h02, 0, 0, 0, 0, 2'd0, 3'd0, 4'd0, 0, 1, 1), "R6");
  endtask

  task automatic do_br(input logic taken);
    opcode = 6'h04;
    fetch(0, "R12");
    br_true = taken;
    step(cw(7'h00, 0, 0, 0, 0, 2'd0, 3'd0, 4'd6, 0, 0, 0), "R7");
    br_true = ~taken;   // only the compare-cycle value may count
    step(cw(taken ? 7'h08 : 7'h00, 0, 0, 0, 0, 2'd1, 3'd1, 4'd0, 0, 0, 0), "R7");
    br_true = 1'b0;
  endtask

  task automatic do_bad(input logic [5:0] op);
    opcode = op;
    fetch(0, "R12");
    mem_rdy = 1'b0;
    step(W_F0, "R10");
    step(W_F1W, "R10");
    opcode = 6'h02;
    mem_rdy = 1'b1;
    step(W_F1R, "R10");
    step(W_RD, "R10");
    step(W_JMP, "R8");
  endtask

  initial begin
    @(negedge clk);
    step(W_F0, "R11");
    step(W_F0, "R11");
    rst = 1'b0;
    do_rr(6'h20, 0);
    do_rr(6'h25, 2);
    do_ri(6'h08);
    do_ri(6'h0D);
    do_ld(1, 0);
    do_ld(0, 3);
    do_st(2);
    do_br(1'b1);
    do_br(1'b0);
    opcode = 6'h02; fetch(0, "R12"); step(W_JMP, "R8");
    opcode = 6'h12; fetch(0, "R12");
    step(cw(7'h08, 0, 0, 0, 0, 2'd0, 3'd1, 4'd0, 0, 0, 0), "R8");
    opcode = 6'h03; fetch(0, "R12");
    step(cw(7'h00, 1, 0, 1, 1, 2'd0, 3'd0, 4'd0, 0, 0, 0), "R9");
    step(W_JMP, "R9");
    do_bad(6'h3F);
    do_bad(6'h0E);
    // reset while a store waits for memory
    st_front();
    mem_rdy = 1'b0;
    step(cw(7'h02, 0, 0, 0, 0, 2'd0, 3'd0, 4'd0, 0, 1, 1), "R6");
    rst = 1'b1;
    step(cw(7'h02, 0, 0, 0, 0, 2'd0, 3'd0, 4'd0, 0, 1, 1), "R11");
    rst = 1'b0;
    do_rr(6'h22, 0);   // first word here is the fetch word forced by reset
    step(W_F0, "R12");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule